// File: doc/BRIEF.md
# Queue Interrupt Status Aggregator

This block gathers completion and error pulses from up to fifteen transmit and fifteen receive queue engines. It holds them in status registers that software can read and acknowledge, and it drives one interrupt line. Each engine reports on single-cycle pulse inputs, with one bit for each endpoint and each event type. Software reaches the block over a plain 32-bit bus that has an address, a write strobe, write data and combinational read data.

Completion events always latch into a shared done register. Error events latch into three per-endpoint error registers, but only where the matching per-endpoint enable bit is set. A read-only summary word shows which error classes currently hold any latched bit. The interrupt rises when an enabled done bit or an enabled summary bit is set. All status bits are cleared by writing ones. A pulse that arrives in the same cycle as a clear of the same bit keeps that bit set. Endpoint slot 0 is reserved in every register.

Top module: `qint_aggr`

## Requirements
- R1: The done status register at byte offset 0x00 latches a transmit completion for endpoint n at bit n and a receive completion at bit 16+n. It latches whether or not the done enable is set.
- R2: Writing a 1 to a bit of any status register (0x00, 0x10, 0x14, 0x18) clears that bit. Writing a 0 leaves the bit unchanged.
- R3: An event that arrives in the same cycle as a write-one clear of its own bit leaves the bit set.
- R4: The error registers use this layout. At 0x10, receive checksum error is bit n and receive length error is bit 16+n. At 0x14, receive zero-length packet is bit n. At 0x18, transmit checksum error is bit n and transmit length error is bit 16+n.
- R5: An error event sets its status bit only when the same bit position is set in its enable register. These are 0x1C for 0x10, 0x20 for 0x14 and 0x24 for 0x18.
- R6: The summary word at 0x08 is read-only. Its bits are 0 receive checksum, 1 receive length, 2 receive zero-length, 3 transmit checksum and 4 transmit length. Each bit is the OR of the matching per-endpoint status bits, and bits 31:5 read zero.
- R7: `irq` is high exactly when some bit of (done status AND done enable at 0x04) is set, or some bit of (summary AND exception enable at 0x0C bits 4:0) is set.
- R8: Bits 0 and 16 of every status and enable register read zero, and events on endpoint 0 are ignored.
- R9: After reset every register reads zero and `irq` is low. Addresses that are not mapped read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tx_done_evt | input | 16 | Transmit completion pulse, bit per endpoint |
| rx_done_evt | input | 16 | Receive completion pulse, bit per endpoint |
| rx_cs_evt | input | 16 | Receive checksum error pulse |
| rx_len_evt | input | 16 | Receive length error pulse |
| rx_zlp_evt | input | 16 | Receive zero-length packet pulse |
| tx_cs_evt | input | 16 | Transmit checksum error pulse |
| tx_len_evt | input | 16 | Transmit length error pulse |
| irq | output | 1 | Interrupt summary |

## Verification
A table sends one pulse of each of the seven event types, each at a different endpoint including slot 15 and slot 0. After each pulse the bench reads the target register, the summary word and the interrupt. This separates each event's bit position and register from every other one, and it shows that the summary bits do not share positions. Directed patterns then cover the following:
- Two bits set together and then cleared partially, with all-zero and single-one writes, which separates a true write-one clear from a plain overwrite.
- A clear that collides with a new event.
- A masked and an unmasked error enable on neighbouring endpoints.
- Done and exception events latched with their enable off and then with it turned on, which separates latching from the interrupt mask.

// File: rtl/qint_pkg.sv
package qint_pkg;

    localparam int unsigned EP_SLOTS  = 16;
    localparam int unsigned REG_W     = 2 * EP_SLOTS;
    localparam int unsigned ADDR_W    = 8;
    localparam int unsigned NUM_BANKS = 4;
    localparam int unsigned EXC_W     = 5;

    localparam int BK_DONE  = 0;
    localparam int BK_RXERR = 1;
    localparam int BK_RXZLP = 2;
    localparam int BK_TXERR = 3;

    localparam logic [ADDR_W-1:0] OFF_SUM    = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_EXC_EN = 8'h0C;

    // Summary word, bit 0 is rx checksum
    typedef struct packed {
        logic tx_len;
        logic tx_cs;
        logic rx_zlp;
        logic rx_len;
        logic rx_cs;
    } exc_sum_t;

    function automatic logic [ADDR_W-1:0] stat_off(input int bank);
        case (bank)
            BK_DONE:  return 8'h00;
            BK_RXERR: return 8'h10;
            BK_RXZLP: return 8'h14;
            default:  return 8'h18;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] en_off(input int bank);
        case (bank)
            BK_DONE:  return 8'h04;
            BK_RXERR: return 8'h1C;
            BK_RXZLP: return 8'h20;
            default:  return 8'h24;
        endcase
    endfunction

    // Implemented bits: endpoint slot 0 reserved in each half
    function automatic logic [REG_W-1:0] keep_mask(input int bank);
        logic [EP_SLOTS-1:0] half;
        half = {{(EP_SLOTS-1){1'b1}}, 1'b0};
        if (bank == BK_RXZLP)
            return {{EP_SLOTS{1'b0}}, half};
        return {half, half};
    endfunction

endpackage

// File: rtl/qint_w1c_bank.sv
module qint_w1c_bank #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);
    // set has priority over clear of the same bit
    always_ff @(posedge clk) begin
        if (rst)
            stat_o <= '0;
        else
            stat_o <= ((stat_o & ~clr_i) | set_i) & KEEP;
    end
endmodule

// File: rtl/qint_mask_reg.sv
module qint_mask_reg #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] KEEP = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (we)
            q <= wdata & KEEP;
    end
endmodule

// File: rtl/qint_exc_summary.sv
module qint_exc_summary
    import qint_pkg::*;
(
    input  logic [REG_W-1:0]    rx_err,
    input  logic [EP_SLOTS-1:0] rx_zlp,
    input  logic [REG_W-1:0]    tx_err,
    output exc_sum_t            sum
);
    always_comb begin
        sum.rx_cs  = |rx_err[EP_SLOTS-1:0];
        sum.rx_len = |rx_err[REG_W-1:EP_SLOTS];
        sum.rx_zlp = |rx_zlp;
        sum.tx_cs  = |tx_err[EP_SLOTS-1:0];
        sum.tx_len = |tx_err[REG_W-1:EP_SLOTS];
    end
endmodule

// File: rtl/qint_aggr.sv
module qint_aggr
    import qint_pkg::*;
#(
    parameter int unsigned AW = qint_pkg::ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [AW-1:0]       bus_addr,
    input  logic                bus_we,
    input  logic [REG_W-1:0]    bus_wdata,
    output logic [REG_W-1:0]    bus_rdata,
    input  logic [EP_SLOTS-1:0] tx_done_evt,
    input  logic [EP_SLOTS-1:0] rx_done_evt,
    input  logic [EP_SLOTS-1:0] rx_cs_evt,
    input  logic [EP_SLOTS-1:0] rx_len_evt,
    input  logic [EP_SLOTS-1:0] rx_zlp_evt,
    input  logic [EP_SLOTS-1:0] tx_cs_evt,
    input  logic [EP_SLOTS-1:0] tx_len_evt,
    output logic                irq
);
    logic [REG_W-1:0] stat_q [NUM_BANKS];
    logic [REG_W-1:0] en_q   [NUM_BANKS];
    logic [REG_W-1:0] raw_v  [NUM_BANKS];
    logic [REG_W-1:0] set_v  [NUM_BANKS];
    logic [REG_W-1:0] clr_v  [NUM_BANKS];
    logic [EXC_W-1:0] exc_en_q;
    exc_sum_t         sum;

    assign raw_v[BK_DONE]  = {rx_done_evt, tx_done_evt};
    assign raw_v[BK_RXERR] = {rx_len_evt, rx_cs_evt};
    assign raw_v[BK_RXZLP] = {{EP_SLOTS{1'b0}}, rx_zlp_evt};
    assign raw_v[BK_TXERR] = {tx_len_evt, tx_cs_evt};

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [REG_W-1:0] KEEP_B = keep_mask(b);
        logic en_wr;

        assign en_wr = bus_we && (bus_addr == AW'(en_off(b)));
        // done events latch unconditionally; error events are gated
        assign set_v[b] = (b == BK_DONE) ? raw_v[b] : (raw_v[b] & en_q[b]);
        assign clr_v[b] = (bus_we && (bus_addr == AW'(stat_off(b)))) ? bus_wdata : '0;

        qint_w1c_bank #(.W(REG_W), .KEEP(KEEP_B)) i_stat (
            .clk    (clk),
            .rst    (rst),
            .set_i  (set_v[b]),
            .clr_i  (clr_v[b]),
            .stat_o (stat_q[b])
        );

        qint_mask_reg #(.W(REG_W), .KEEP(KEEP_B)) i_en (
            .clk   (clk),
            .rst   (rst),
            .we    (en_wr),
            .wdata (bus_wdata),
            .q     (en_q[b])
        );
    end

    qint_mask_reg #(.W(EXC_W), .KEEP('1)) i_exc_en (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we && (bus_addr == AW'(OFF_EXC_EN))),
        .wdata (bus_wdata[EXC_W-1:0]),
        .q     (exc_en_q)
    );

    qint_exc_summary i_sum (
        .rx_err (stat_q[BK_RXERR]),
        .rx_zlp (stat_q[BK_RXZLP][EP_SLOTS-1:0]),
        .tx_err (stat_q[BK_TXERR]),
        .sum    (sum)
    );

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == AW'(stat_off(b))) bus_rdata = stat_q[b];
            if (bus_addr == AW'(en_off(b)))   bus_rdata = en_q[b];
        end
        if (bus_addr == AW'(OFF_SUM))    bus_rdata = REG_W'(sum);
        if (bus_addr == AW'(OFF_EXC_EN)) bus_rdata = REG_W'(exc_en_q);
    end

    assign irq = (|(stat_q[BK_DONE] & en_q[BK_DONE])) || (|(sum & exc_en_q));

endmodule

// File: rtl/qint_aggr_chk.sv
module qint_aggr_chk
    import qint_pkg::*;
#(
    parameter int unsigned AW = qint_pkg::ADDR_W
) (
    input logic                clk,
    input logic                rst,
    input logic [AW-1:0]       bus_addr,
    input logic                bus_we,
    input logic [REG_W-1:0]    bus_wdata,
    input logic [REG_W-1:0]    bus_rdata,
    input logic [EP_SLOTS-1:0] tx_done_evt,
    input logic [EP_SLOTS-1:0] rx_done_evt,
    input logic [REG_W-1:0]    done_q,
    input logic [REG_W-1:0]    rx_err_q,
    input logic [REG_W-1:0]    rx_err_en,
    input logic [EXC_W-1:0]    sum_bits,
    input logic                irq
);
    localparam logic [REG_W-1:0] DUAL = keep_mask(BK_DONE);
    logic [REG_W-1:0] ev;
    assign ev = {rx_done_evt, tx_done_evt};

    // R2: a write-one with no event pending clears the written bits
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(8'h00) && ev == '0) |=> ((done_q & $past(bus_wdata)) == '0));

    // R3: event colliding with a clear keeps its bit
    a_r3_event_wins: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_addr == AW'(8'h00) && ((bus_wdata & ev & DUAL) != '0))
        |=> ((done_q & $past(bus_wdata & ev & DUAL)) == $past(bus_wdata & ev & DUAL)));

    // R5: no newly set error bit without its enable
    a_r5_gated_set: assert property (@(posedge clk) disable iff (rst)
        ((rx_err_q & ~$past(rx_err_q) & ~$past(rx_err_en)) == '0));

    // R6: upper bits of the summary word read zero
    a_r6_sum_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(8'h08)) |-> (bus_rdata[REG_W-1:EXC_W] == '0));

    // R7: interrupt only with some latched source
    a_r7_irq_has_source: assert property (@(posedge clk) disable iff (rst)
        irq |-> ((done_q != '0) || (sum_bits != '0)));

    // R8: endpoint 0 bits of done status read zero
    a_r8_ep0_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == AW'(8'h00)) |-> (!bus_rdata[0] && !bus_rdata[EP_SLOTS]));

    // R9: interrupt low right after reset
    a_r9_reset_quiet: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> !irq);
endmodule

bind qint_aggr qint_aggr_chk #(.AW(AW)) i_qint_aggr_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .tx_done_evt (tx_done_evt),
    .rx_done_evt (rx_done_evt),
    .done_q      (stat_q[0]),
    .rx_err_q    (stat_q[1]),
    .rx_err_en   (en_q[1]),
    .sum_bits    (sum),
    .irq         (irq)
);

// File: tb/test_qint_aggr.sv
`timescale 1ns/1ps
module test_qint_aggr;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] ev [7];
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    initial for (int k = 0; k < 7; k++) ev[k] = '0;

    qint_aggr i_qint_aggr (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_done_evt(ev[0]), .rx_done_evt(ev[1]), .rx_cs_evt(ev[2]), .rx_len_evt(ev[3]),
        .rx_zlp_evt(ev[4]), .tx_cs_evt(ev[5]), .tx_len_evt(ev[6]),
        .irq(irq)
    );

    // kind: 0 tx done, 1 rx done, 2 rx cs, 3 rx len, 4 rx zlp, 5 tx cs, 6 tx len
    typedef struct packed {
        logic [2:0]  kind;
        logic [3:0]  ep;
        logic [7:0]  addr;
        logic [31:0] val;
        logic [4:0]  sum;
        logic        irq;
    } row_t;

    localparam row_t VEC [0:7] = '{
        '{3'd0, 4'd3,  8'h00, 32'h0000_0008, 5'h00, 1'b1},
        '{3'd1, 4'd5,  8'h00, 32'h0020_0000, 5'h00, 1'b1},
        '{3'd2, 4'd1,  8'h10, 32'h0000_0002, 5'h01, 1'b1},
        '{3'd3, 4'd15, 8'h10, 32'h8000_0000, 5'h02, 1'b1},
        '{3'd4, 4'd7,  8'h14, 32'h0000_0080, 5'h04, 1'b1},
        '{3'd5, 4'd2,  8'h18, 32'h0000_0004, 5'h08, 1'b1},
        '{3'd6, 4'd9,  8'h18, 32'h0200_0000, 5'h10, 1'b1},
        '{3'd0, 4'd0,  8'h00, 32'h0000_0000, 5'h00, 1'b0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        @(negedge clk);
        #1;
        check(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic pulse(input int kind, input logic [15:0] m);
        @(negedge clk);
        ev[kind] = m;
        @(negedge clk);
        ev[kind] = '0;
    endtask

    task automatic pulse_wr(input int kind, input logic [15:0] m, input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        ev[kind] = m; bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        ev[kind] = '0; bus_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R9: reset state of every register and irq
        for (int a = 0; a <= 8'h24; a += 4) rd(8'(a), 32'h0, "R9 reset read");
        rd(8'h40, 32'h0, "R9 unmapped read");
        chk_irq(1'b0, "R9 irq after reset");

        // R8: enables ignore endpoint 0 slots
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h04, 32'hFFFE_FFFE, "R8 done enable readback");
        rd(8'h20, 32'h0000_FFFE, "R8 zlp enable readback");
        rd(8'h0C, 32'h0000_001F, "R7 exc enable readback");

        // R1/R4/R6/R7/R8: table walk
        for (int i = 0; i < 8; i++) begin
            pulse(int'(VEC[i].kind), 16'(1) << VEC[i].ep);
            rd(VEC[i].addr, VEC[i].val, "R1/R4 table status");
            rd(8'h08, {27'b0, VEC[i].sum}, "R6 table summary");
            chk_irq(VEC[i].irq, "R7 table irq");
            wr(VEC[i].addr, 32'hFFFF_FFFF);
            chk_irq(1'b0, "R2 table irq after clear");
        end

        // R2: write-zero keeps, write-one clears only its bit
        pulse(0, 16'h0018);
        rd(8'h00, 32'h0000_0018, "R1 two done bits");
        wr(8'h00, 32'h0);
        rd(8'h00, 32'h0000_0018, "R2 write zero keeps");
        wr(8'h00, 32'h0000_0008);
        rd(8'h00, 32'h0000_0010, "R2 partial clear");
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, 32'h0, "R2 full clear");

        // R3: event collides with clear
        pulse_wr(0, 16'h0040, 8'h00, 32'h0000_0040);
        rd(8'h00, 32'h0000_0040, "R3 done event wins");
        pulse_wr(2, 16'h0004, 8'h10, 32'h0000_0004);
        rd(8'h10, 32'h0000_0004, "R3 error event wins");
        wr(8'h00, 32'hFFFF_FFFF);
        wr(8'h10, 32'hFFFF_FFFF);

        // R5: error enable gating
        wr(8'h1C, 32'h0000_0002);
        pulse(2, 16'h0004);
        rd(8'h10, 32'h0, "R5 masked error not latched");
        pulse(2, 16'h0002);
        rd(8'h10, 32'h0000_0002, "R5 enabled error latched");
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h1C, 32'hFFFF_FFFF);

        // R7: done enable masks irq but not latching
        wr(8'h04, 32'h0);
        pulse(1, 16'h0010);
        rd(8'h00, 32'h0010_0000, "R1 done latched with enable off");
        chk_irq(1'b0, "R7 done masked");
        wr(8'h04, 32'h0010_0000);
        chk_irq(1'b1, "R7 done unmasked");
        wr(8'h00, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R7 done cleared");

        // R7/R6: exception enable masks summary
        wr(8'h0C, 32'h0000_001E);
        pulse(2, 16'h0008);
        rd(8'h08, 32'h0000_0001, "R6 summary rx cs");
        chk_irq(1'b0, "R7 exception masked");
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'h0000_0001, "R6 summary read-only");
        wr(8'h0C, 32'h0000_001F);
        chk_irq(1'b1, "R7 exception unmasked");
        wr(8'h10, 32'hFFFF_FFFF);
        chk_irq(1'b0, "R7 exception cleared");

        // R8: endpoint 0 events ignored everywhere
        for (int k = 0; k < 7; k++) pulse(k, 16'h0001);
        rd(8'h00, 32'h0, "R8 ep0 done");
        rd(8'h10, 32'h0, "R8 ep0 rx err");
        rd(8'h14, 32'h0, "R8 ep0 rx zlp");
        rd(8'h18, 32'h0, "R8 ep0 tx err");
        chk_irq(1'b0, "R8 ep0 irq");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule